// File: doc/BRIEF.md
# Event-Selectable Cache Performance Counter Bank

A bank of four accumulating counters for observing cache activity. Each counter owns a configuration word that picks one event code and an optional clear-on-read flag. Every clock, each counter adds the per-cycle increment of its chosen event. Event activity arrives as a flat vector of 5-bit lanes. Some lanes are plain pulses, some carry occupancy counts, and some carry bank-usage counts of 0 to 4.

Software programs the configuration words through a write strobe. It reads either a counter value or a configuration word through a read strobe, with one cycle of latency. Writing a configuration never disturbs the accumulated count. A read of a counter whose clear-on-read flag is set hands back the current value and restarts the counter.

Top module: `perf_ctr_bank`

## Requirements
- R1: After synchronous reset every counter reads 0 and every configuration word reads 0 (event code 0, clear-on-read off).
- R2: A write with `cfg_we` high loads `cfg_wdata` into the configuration of counter `cfg_idx`: bits 7:0 hold the event code and bit 8 holds the clear-on-read flag. Reading `rd_addr` = 4 + index returns that word in the same bit positions, with zeros above.
- R3: Writing a counter's configuration leaves its accumulated value unchanged.
- R4: Event code 0 adds nothing. Every unassigned code also adds nothing: codes 10 to 127, codes 192 to 255, and codes 128 to 191 whose low nibble exceeds 3.
- R5: Lane L occupies `evt_lanes[5L+4:5L]`. Single-bit events add only bit 0 of their lane. Codes 1 to 6 use lanes 0 to 5. Quadrant codes 128+16q+k with k=0 (index bus) or k=1 (read bus) use lane 9+4q+k.
- R6: Occupancy codes 7, 8 and 9 use lanes 6, 7 and 8 and add the full 5-bit lane value each cycle.
- R7: Quadrant codes 128+16q+k with k=2 (banks in use) or k=3 (write-data flops in use) use lane 9+4q+k and add the lane value limited to at most 4.
- R8: `rd_en` with `rd_addr[2]` = 0 reads counter `rd_addr[1:0]`. On the next cycle `rd_valid` is high and `rd_data` holds the value the counter had in the read cycle. `rd_valid` is low after cycles without `rd_en`.
- R9: A counter read with clear-on-read set restarts that counter, so the next cycle it equals the increment of the read cycle.
- R10: A counter read with clear-on-read off leaves the counter accumulating normally.
- R11: Counters wrap modulo 2^CTR_W on overflow.
- R12: The counters are independent, and one event may be selected by several counters at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| evt_lanes | input | 125 | Per-cycle increments, 25 lanes of 5 bits |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_idx | input | 2 | Counter whose configuration is written |
| cfg_wdata | input | 9 | Configuration word: flag in bit 8, event code in bits 7:0 |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 3 | Bit 2 selects configuration (1) or counter (0), bits 1:0 the counter |
| rd_data | output | 64 | Read result, valid one cycle after `rd_en` |
| rd_valid | output | 1 | High in the cycle `rd_data` is valid |

## Verification
Two pairs of events can fall in the same cycle. A clear-on-read read can coincide with a nonzero increment, and a configuration write can coincide with a read of the same counter. The bench provokes both by reading the same counter on back-to-back cycles, and by issuing a write and a read together while the event lanes change pseudo-randomly. A model built from the requirements predicts each returned value. The model restarts from the read cycle's increment and keeps the old configuration in effect for the colliding cycle.

// File: rtl/perf_pkg.sv
package perf_pkg;

    localparam int unsigned CODE_W      = 8;
    localparam int unsigned INC_W       = 5;
    localparam int unsigned NUM_SIMPLE  = 9;
    localparam int unsigned PULSE_FIRST = 1;
    localparam int unsigned PULSE_LAST  = 6;
    localparam int unsigned OCC_FIRST   = 7;
    localparam int unsigned OCC_LAST    = 9;
    localparam int unsigned QUAD_BASE   = 128;
    localparam int unsigned QUAD_STRIDE = 16;
    localparam int unsigned NUM_QUAD    = 4;
    localparam int unsigned QUAD_KINDS  = 4;
    localparam int unsigned QUAD_PULSES = 2;
    localparam int unsigned BANK_MAX    = 4;
    localparam int unsigned NUM_LANES   = NUM_SIMPLE + NUM_QUAD * QUAD_KINDS;
    localparam int unsigned LANE_W      = $clog2(NUM_LANES);
    localparam int unsigned EVT_W       = NUM_LANES * INC_W;

    typedef enum logic [1:0] {
        EK_NONE  = 2'd0,
        EK_PULSE = 2'd1,
        EK_OCC   = 2'd2,
        EK_CLAMP = 2'd3
    } evt_kind_e;

    typedef struct packed {
        evt_kind_e         kind;
        logic [LANE_W-1:0] lane;
    } evt_route_t;

    typedef struct packed {
        logic              clr_on_rd;
        logic [CODE_W-1:0] code;
    } ctr_cfg_t;

    localparam int unsigned CFG_W = $bits(ctr_cfg_t);

    // Map an event code onto the lane it reads and the way that lane is summed.
    function automatic evt_route_t route_of(input logic [CODE_W-1:0] code);
        evt_route_t  r;
        int unsigned c;
        int unsigned off;
        int unsigned k;
        c      = 32'(code);
        r.kind = EK_NONE;
        r.lane = '0;
        if (c >= PULSE_FIRST && c <= PULSE_LAST) begin
            r.kind = EK_PULSE;
            r.lane = LANE_W'(c - 1);
        end else if (c >= OCC_FIRST && c <= OCC_LAST) begin
            r.kind = EK_OCC;
            r.lane = LANE_W'(c - 1);
        end else if (c >= QUAD_BASE && c < QUAD_BASE + NUM_QUAD * QUAD_STRIDE) begin
            off = c - QUAD_BASE;
            k   = off % QUAD_STRIDE;
            if (k < QUAD_KINDS) begin
                r.lane = LANE_W'(NUM_SIMPLE + (off / QUAD_STRIDE) * QUAD_KINDS + k);
                r.kind = (k < QUAD_PULSES) ? EK_PULSE : EK_CLAMP;
            end
        end
        return r;
    endfunction

endpackage

// File: rtl/perf_evt_sel.sv
module perf_evt_sel
    import perf_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [CODE_W-1:0] code,
    input  logic [EVT_W-1:0]  evt_lanes,
    output logic [INC_W-1:0]  inc
);

    evt_route_t       route;
    logic [INC_W-1:0] lane_val;

    always_comb begin
        route    = route_of(code);
        lane_val = evt_lanes[32'(route.lane) * INC_W +: INC_W];
        case (route.kind)
            EK_PULSE: inc = INC_W'(lane_val[0]);
            EK_OCC:   inc = lane_val;
            EK_CLAMP: inc = (lane_val > INC_W'(BANK_MAX)) ? INC_W'(BANK_MAX) : lane_val;
            default:  inc = '0;
        endcase
    end

    // R5: a pulse lane never contributes more than one per cycle
    assert_pulse_single_R5: assert property (@(posedge clk) disable iff (rst)
        (route.kind == EK_PULSE) |-> (inc <= INC_W'(1)));

    // R7: bank-style lanes never contribute more than the limit
    assert_bank_limit_R7: assert property (@(posedge clk) disable iff (rst)
        (route.kind == EK_CLAMP) |-> (inc <= INC_W'(BANK_MAX)));

endmodule

// File: rtl/perf_ctr_cell.sv
module perf_ctr_cell
    import perf_pkg::*;
#(
    parameter int unsigned CTR_W = 64
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_we,
    input  logic [CFG_W-1:0] cfg_wdata,
    input  logic             rd_hit,
    input  logic [EVT_W-1:0] evt_lanes,
    output logic [CTR_W-1:0] ctr_val,
    output logic [CFG_W-1:0] cfg_val
);

    ctr_cfg_t         cfg_q;
    logic [CTR_W-1:0] ctr_q;
    logic [INC_W-1:0] inc;
    logic             wipe;

    perf_evt_sel u_sel (
        .clk       (clk),
        .rst       (rst),
        .code      (cfg_q.code),
        .evt_lanes (evt_lanes),
        .inc       (inc)
    );

    assign wipe = rd_hit && cfg_q.clr_on_rd;

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            ctr_q <= '0;
        end else begin
            if (cfg_we) cfg_q <= ctr_cfg_t'(cfg_wdata);
            ctr_q <= (wipe ? '0 : ctr_q) + CTR_W'(inc);
        end
    end

    assign ctr_val = ctr_q;
    assign cfg_val = cfg_q;

    // R4: a counter on code zero does not move unless it is being cleared
    assert_idle_code_holds_R4: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.code == '0 && !wipe) |=> $stable(ctr_q));

    // R9: a clearing read restarts the count at the increment seen that cycle
    assert_clear_restart_R9: assert property (@(posedge clk) disable iff (rst)
        wipe |=> (ctr_q == CTR_W'($past(inc))));

    // R10: a plain read with no activity leaves the count alone
    assert_plain_read_R10: assert property (@(posedge clk) disable iff (rst)
        (rd_hit && !cfg_q.clr_on_rd && inc == '0) |=> $stable(ctr_q));

    // R3: a configuration write with no activity leaves the count alone
    assert_cfg_keeps_R3: assert property (@(posedge clk) disable iff (rst)
        (cfg_we && !wipe && inc == '0) |=> $stable(ctr_q));

endmodule

// File: rtl/perf_rd_port.sv
module perf_rd_port
    import perf_pkg::*;
#(
    parameter int unsigned NUM_CTR = 4,
    parameter int unsigned CTR_W   = 64,
    parameter int unsigned DATA_W  = 64,
    parameter int unsigned IDX_W   = 2
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            rd_en,
    input  logic [IDX_W:0]                  rd_addr,
    input  logic [NUM_CTR-1:0][CTR_W-1:0]   ctr_vals,
    input  logic [NUM_CTR-1:0][CFG_W-1:0]   cfg_vals,
    output logic [NUM_CTR-1:0]              rd_hit,
    output logic [DATA_W-1:0]               rd_data,
    output logic                            rd_valid
);

    logic [IDX_W-1:0] rd_idx;
    logic             sel_cfg;
    logic [CTR_W-1:0] pick_ctr;
    logic [CFG_W-1:0] pick_cfg;

    assign rd_idx  = rd_addr[IDX_W-1:0];
    assign sel_cfg = rd_addr[IDX_W];

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_hit
        assign rd_hit[i] = rd_en && !sel_cfg && (rd_idx == IDX_W'(i));
    end

    always_comb begin
        pick_ctr = '0;
        pick_cfg = '0;
        for (int i = 0; i < NUM_CTR; i++) begin
            if (rd_idx == IDX_W'(i)) begin
                pick_ctr = ctr_vals[i];
                pick_cfg = cfg_vals[i];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_valid <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= rd_en;
            if (rd_en) rd_data <= sel_cfg ? DATA_W'(pick_cfg) : DATA_W'(pick_ctr);
        end
    end

endmodule

// File: rtl/perf_ctr_bank.sv
module perf_ctr_bank
    import perf_pkg::*;
#(
    parameter  int unsigned NUM_CTR = 4,
    parameter  int unsigned CTR_W   = 64,
    parameter  int unsigned DATA_W  = 64,
    localparam int unsigned IDX_W   = (NUM_CTR > 1) ? $clog2(NUM_CTR) : 1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [EVT_W-1:0]  evt_lanes,
    input  logic              cfg_we,
    input  logic [IDX_W-1:0]  cfg_idx,
    input  logic [CFG_W-1:0]  cfg_wdata,
    input  logic              rd_en,
    input  logic [IDX_W:0]    rd_addr,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);

    logic [NUM_CTR-1:0][CTR_W-1:0] ctr_vals;
    logic [NUM_CTR-1:0][CFG_W-1:0] cfg_vals;
    logic [NUM_CTR-1:0]            rd_hit;

    for (genvar i = 0; i < NUM_CTR; i++) begin : g_ctr
        perf_ctr_cell #(.CTR_W(CTR_W)) u_cell (
            .clk       (clk),
            .rst       (rst),
            .cfg_we    (cfg_we && (cfg_idx == IDX_W'(i))),
            .cfg_wdata (cfg_wdata),
            .rd_hit    (rd_hit[i]),
            .evt_lanes (evt_lanes),
            .ctr_val   (ctr_vals[i]),
            .cfg_val   (cfg_vals[i])
        );
    end

    perf_rd_port #(
        .NUM_CTR (NUM_CTR),
        .CTR_W   (CTR_W),
        .DATA_W  (DATA_W),
        .IDX_W   (IDX_W)
    ) u_rd (
        .clk      (clk),
        .rst      (rst),
        .rd_en    (rd_en),
        .rd_addr  (rd_addr),
        .ctr_vals (ctr_vals),
        .cfg_vals (cfg_vals),
        .rd_hit   (rd_hit),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

endmodule

// File: tb/tb_perf_ctr_bank.sv
module tb_perf_ctr_bank;

    localparam int CLK_PERIOD = 10;
    localparam int CW         = 12;
    localparam int NL         = 25;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic [124:0] evt = '0;
    logic         cfg_we = 1'b0;
    logic [1:0]   cfg_idx = '0;
    logic [8:0]   cfg_wdata = '0;
    logic         rd_en = 1'b0;
    logic [2:0]   rd_addr = '0;
    logic [63:0]  rd_data;
    logic         rd_valid;

    perf_ctr_bank #(.CTR_W(CW)) dut (
        .clk(clk), .rst(rst), .evt_lanes(evt), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_wdata(cfg_wdata), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_data(rd_data), .rd_valid(rd_valid)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    typedef struct { logic [63:0] exp; string tag; } exp_t;
    exp_t q[$];

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    logic [CW-1:0] m_ctr [4];
    logic [7:0]    m_code[4];
    logic          m_cor [4];
    logic          rd_prev = 1'b0;

    bit           rand_on = 0;
    logic [124:0] evt_fixed = '0;
    logic [31:0]  lfsr = 32'h1234_5678;

    // Expected per-cycle increment, from the requirements
    function automatic int exp_inc(input logic [7:0] code, input logic [124:0] e);
        int c = int'(code);
        int off, k, qd, v;
        if (c >= 1 && c <= 6) return int'(e[(c-1)*5]);
        if (c >= 7 && c <= 9) return int'(e[(c-1)*5 +: 5]);
        if (c >= 128 && c < 192) begin
            off = c - 128; qd = off / 16; k = off % 16;
            if (k > 3) return 0;
            v = int'(e[(9 + 4*qd + k)*5 +: 5]);
            if (k < 2) return v & 1;
            return (v > 4) ? 4 : v;
        end
        return 0;
    endfunction

    // Stimulus for event lanes
    always @(negedge clk) begin
        lfsr = lfsr ^ (lfsr << 13);
        lfsr = lfsr ^ (lfsr >> 17);
        lfsr = lfsr ^ (lfsr << 5);
        if (rand_on) evt <= 125'({lfsr, lfsr ^ 32'hA5A5_5A5A, ~lfsr, {lfsr[15:0], lfsr[31:16]}});
        else         evt <= evt_fixed;
    end

    // Reference model
    always @(posedge clk) begin
        rd_prev <= rd_en;
        if (rst) begin
            for (int i = 0; i < 4; i++) begin
                m_ctr[i] <= '0; m_code[i] <= '0; m_cor[i] <= 1'b0;
            end
        end else begin
            for (int i = 0; i < 4; i++) begin
                logic clr;
                clr = rd_en && !rd_addr[2] && (rd_addr[1:0] == 2'(i)) && m_cor[i];
                m_ctr[i] <= (clr ? '0 : m_ctr[i]) + CW'(exp_inc(m_code[i], evt));
            end
            if (cfg_we) begin
                m_code[cfg_idx] <= cfg_wdata[7:0];
                m_cor[cfg_idx]  <= cfg_wdata[8];
            end
        end
    end

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (!rst && !done) begin
            if (rd_valid !== rd_prev) begin
                n_chk++; n_fail++;
                $display("FAIL R8 rd_valid timing: actual %0b expected %0b", rd_valid, rd_prev);
            end
            if (rd_valid && rd_prev) begin
                exp_t it;
                n_chk++;
                if (q.size() == 0) begin
                    n_fail++;
                    $display("FAIL R8 unexpected result: actual %0h expected none", rd_data);
                end else begin
                    it = q.pop_front();
                    if (rd_data !== it.exp) begin
                        n_fail++;
                        $display("FAIL %s: actual %0h expected %0h", it.tag, rd_data, it.exp);
                    end
                end
            end
        end
    end

    function automatic logic [63:0] model_read(input logic [2:0] a);
        if (a[2]) return 64'({m_cor[a[1:0]], m_code[a[1:0]]});
        return 64'(m_ctr[a[1:0]]);
    endfunction

    task automatic issue_rd(input logic [2:0] a, input string tag);
        exp_t it;
        @(negedge clk);
        cfg_we = 1'b0; rd_en = 1'b1; rd_addr = a;
        it.exp = model_read(a); it.tag = tag;
        q.push_back(it);
    endtask

    task automatic issue_cfg(input int idx, input bit cor, input int code);
        @(negedge clk);
        rd_en = 1'b0; cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = {cor, 8'(code)};
    endtask

    task automatic issue_both(input int idx, input bit cor, input int code,
                              input logic [2:0] a, input string tag);
        exp_t it;
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = 2'(idx); cfg_wdata = {cor, 8'(code)};
        rd_en = 1'b1; rd_addr = a;
        it.exp = model_read(a); it.tag = tag;
        q.push_back(it);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            rd_en = 1'b0; cfg_we = 1'b0;
        end
    endtask

    task automatic fill(input int v);
        for (int l = 0; l < NL; l++) evt_fixed[l*5 +: 5] = 5'(v);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        int codes[10] = '{176, 177, 178, 179, 145, 161, 8, 9, 3, 147};
        int dead[6]   = '{10, 127, 132, 191, 192, 255};
        repeat (4) @(posedge clk);
        @(negedge clk); rst = 1'b0;

        // R1: reset state of counters and configs
        for (int a = 0; a < 8; a++) issue_rd(3'(a), "R1 reset value");
        idle(2);

        // R2: config write and readback
        issue_cfg(0, 0, 1);
        issue_cfg(1, 0, 7);
        issue_cfg(2, 0, 130);
        issue_cfg(3, 1, 200);
        for (int a = 4; a < 8; a++) issue_rd(3'(a), "R2 config readback");
        idle(2);
        issue_rd(3'd3, "R9 clear before test");
        idle(1);

        // Lanes = 2: pulse bit0 is 0, bank below the limit
        fill(2); idle(6);
        issue_rd(3'd0, "R5 pulse ignores upper bits");
        issue_rd(3'd1, "R6 occupancy full value");
        issue_rd(3'd2, "R7 bank below limit");
        issue_rd(3'd3, "R4 unassigned code adds nothing");
        idle(2);

        // Lanes = 7: pulse bit0 set, bank clamped
        fill(7); idle(6);
        issue_rd(3'd0, "R5 pulse counts bit0");
        issue_rd(3'd1, "R6 occupancy full value");
        issue_rd(3'd2, "R7 bank clamped to limit");
        idle(2);

        // R3 and R4: reconfigure to code 0, value kept and frozen
        issue_cfg(1, 0, 0);
        idle(3);
        issue_rd(3'd1, "R3 config write keeps value");
        idle(5);
        issue_rd(3'd1, "R4 code zero holds value");
        idle(2);

        // R9: clear-on-read back to back with random increments
        rand_on = 1;
        issue_cfg(2, 1, 131);
        idle(4);
        issue_rd(3'd2, "R9 clear-on-read returns value");
        issue_rd(3'd2, "R9 restart at same-cycle increment");
        issue_rd(3'd2, "R9 restart at same-cycle increment");
        idle(3);
        issue_rd(3'd2, "R9 accumulate after clear");
        idle(2);

        // R10: plain reads back to back
        issue_cfg(0, 0, 7);
        idle(4);
        issue_rd(3'd0, "R10 plain read");
        issue_rd(3'd0, "R10 plain read keeps counting");
        idle(3);
        issue_rd(3'd0, "R10 plain read keeps counting");
        idle(2);

        // Collision: config write and read of the same counter together
        issue_both(2, 0, 9, 3'd2, "R9 clear with config write same cycle");
        issue_both(2, 1, 8, 3'd6, "R2 config read during write");
        idle(4);
        issue_rd(3'd2, "R3 value after colliding writes");
        issue_rd(3'd6, "R2 config after colliding write");
        idle(2);

        // R12: same event on two counters, one clearing, one not
        issue_cfg(0, 0, 179);
        issue_cfg(3, 1, 179);
        for (int r = 0; r < 6; r++) begin
            idle(5);
            issue_rd(3'd0, "R12 shared event counter A");
            issue_rd(3'd3, "R12 shared event counter B");
        end
        idle(2);

        // R5 R6 R7 across quadrant and simple codes
        foreach (codes[i]) begin
            issue_cfg(1, 0, codes[i]);
            issue_cfg(2, 1, codes[i]);
            idle(7);
            issue_rd(3'd1, "R7 R5 R6 code sweep plain");
            issue_rd(3'd2, "R7 R5 R6 code sweep clearing");
        end
        idle(2);

        // R4: unassigned codes under random activity
        foreach (dead[i]) begin
            issue_cfg(3, 1, 0);
            issue_rd(3'd3, "R9 clear before idle code");
            issue_cfg(3, 0, dead[i]);
            idle(8);
            issue_rd(3'd3, "R4 unassigned code adds nothing");
        end
        idle(2);

        // R11: wrap of the 12-bit counter
        rand_on = 0;
        fill(31);
        issue_cfg(1, 0, 7);
        idle(150);
        issue_rd(3'd1, "R11 wrap after overflow");
        idle(40);
        issue_rd(3'd1, "R11 wrap continues");
        idle(3);

        if (q.size() != 0) begin
            n_chk++; n_fail++;
            $display("FAIL R8 missing results: actual %0d pending expected 0", q.size());
        end
        finish_run();
    end

endmodule